// File: doc/BRIEF.md
# Terminated Byte Block Packer

This block takes in a stream of 8-bit bytes, each one marked by a one-cycle valid strobe, and writes them in order into an internal RAM. A reserved terminator value, all ones by default, ends the block. Once the block has ended, the block reads the stored bytes back and sends them out as 16-bit words. Each word holds two bytes that were stored one after the other, and each word comes with a single-cycle output strobe.

A block can also end because the RAM is full. In that case the block starts sending as if a terminator had arrived. While it is sending, the block drops its ready output and ignores any input strobes. When the last word has gone out, it clears its write pointer and accepts input again. Any upstream producer can drive the block if it only offers a byte while ready is high.

Top module: `blk_pack_buf`

## Requirements
- R1: While `in_rdy` is high, each byte with `in_vld` high is stored at the next sequential RAM address, starting from address 0.
- R2: A byte equal to `TERM` (8'hFF) ends the block. The terminator is not stored and never appears in the output.
- R3: No output word appears before the block has ended. After the block ends, all words are sent on consecutive cycles.
- R4: Each output word puts the earlier stored byte in bits [15:8] and the later byte in bits [7:0]. Words are sent in storage order.
- R5: `out_vld` is high for exactly one cycle for each word. The number of words is the stored byte count divided by two, rounded up.
- R6: If the stored byte count is odd, the last word carries the final byte in [15:8] and 8'h00 in [7:0].
- R7: When the `DEPTH`-th (64th) byte is stored, intake stops and sending begins without a terminator.
- R8: While sending, `in_rdy` is low and input strobes have no effect on stored data or output words.
- R9: After the last word, `in_rdy` returns high and the next block is stored again from address 0.
- R10: A terminator that arrives with no bytes stored produces no output word, and `in_rdy` stays high.
- R11: Synchronous reset clears the write and read pointers, drops `out_vld`, discards any partial block and forces `in_rdy` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_byte | input | 8 | Incoming byte |
| in_vld | input | 1 | Strobe marking `in_byte` as valid |
| out_word | output | 16 | Packed pair of stored bytes |
| out_vld | output | 1 | One-cycle strobe for each new `out_word` |
| in_rdy | output | 1 | High while the block is accepting bytes |

## Verification
The bench drives blocks of even length, odd length, a single byte and a lone terminator. A design that drops the pad would send a stale low byte, and one that mishandles an empty block would emit a spurious word or hang busy. A 64-byte block with no terminator checks that the RAM-full case starts sending by itself. A 65th byte that follows it must then open a fresh block at address 0, which exposes a write pointer that was not cleared. Strobes driven with junk data while the block is busy, and a reset in the middle of a block, would show up as extra or corrupted words if either one leaked into the RAM.

// File: rtl/blk_pack_buf.sv
module blk_pack_buf #(
  parameter int         DEPTH = 64,
  parameter logic [7:0] TERM  = 8'hFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  in_byte,
  input  logic        in_vld,
  output logic [15:0] out_word,
  output logic        out_vld,
  output logic        in_rdy
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          sending;

  wire           take     = !sending && in_vld;
  wire           is_term  = (in_byte == TERM);
  wire           store    = take && !is_term;
  wire           full_now = store && (wr_ptr == PW'(DEPTH - 1));
  wire [PW-1:0]  rd_nxt   = rd_ptr + PW'(1);
  wire           last     = sending && ((rd_ptr + PW'(2)) >= wr_ptr);
  wire [7:0]     hi_byte  = mem[rd_ptr[AW-1:0]];
  wire [7:0]     lo_byte  = (rd_nxt < wr_ptr) ? mem[rd_nxt[AW-1:0]] : 8'h00;

  assign in_rdy = !sending;

  always_ff @(posedge clk)
    if (store) mem[wr_ptr[AW-1:0]] <= in_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      sending  <= 1'b0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      out_vld  <= 1'b0;
      out_word <= '0;
    end else begin
      out_vld <= sending;
      if (sending) begin
        out_word <= {hi_byte, lo_byte};
        rd_ptr   <= rd_ptr + PW'(2);
        if (last) begin
          sending <= 1'b0;
          wr_ptr  <= '0;
          rd_ptr  <= '0;
        end
      end else begin
        if (store) wr_ptr <= wr_ptr + PW'(1);
        if (full_now) sending <= 1'b1;
        if (take && is_term && wr_ptr != '0) sending <= 1'b1;
      end
    end
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    sending && !last |=> $stable(wr_ptr)); // R8
  AST_WR_BOUND: assert property (@(posedge clk) disable iff (rst)
    wr_ptr <= PW'(DEPTH)); // R7
  AST_TERM_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
    take && is_term |=> wr_ptr == $past(wr_ptr)); // R2
  AST_OUT_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(sending)); // R3
  AST_IDLE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $fell(sending) |-> wr_ptr == '0 && rd_ptr == '0); // R9
  AST_LONE_TERM: assert property (@(posedge clk) disable iff (rst)
    take && is_term && wr_ptr == '0 |=> !sending); // R10
endmodule

// File: tb/blk_pack_buf_bench.sv
module blk_pack_buf_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_byte = 8'h00;
  logic        in_vld = 1'b0;
  logic [15:0] out_word;
  logic        out_vld;
  logic        in_rdy;

  int vectors = 0;
  int errors  = 0;
  logic [15:0] exp_q[$];
  logic [7:0]  pend[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_pack_buf u_blk_pack_buf (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_vld(in_vld),
    .out_word(out_word), .out_vld(out_vld), .in_rdy(in_rdy));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic flush_block();
    for (int i = 0; i < pend.size(); i += 2)
      exp_q.push_back({pend[i], (i + 1 < pend.size()) ? pend[i+1] : 8'h00});
    pend.delete();
  endtask

  task automatic send_byte(input logic [7:0] b);
    while (!in_rdy) @(negedge clk);
    in_byte = b;
    in_vld  = 1'b1;
    if (b == 8'hFF) flush_block();
    else begin
      pend.push_back(b);
      if (pend.size() == 64) flush_block();
    end
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !in_rdy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0 && in_rdy, "R9 idle after block", {31'd0, in_rdy}, 32'd1);
  endtask

  always @(negedge clk) begin
    if (!rst && out_vld) begin
      if (exp_q.size() == 0) check(1'b0, "R3 R5 unexpected word", {16'd0, out_word}, 32'hxxxx);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(out_word === e, "R4 R6 word", {16'd0, out_word}, {16'd0, e});
      end
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(in_rdy === 1'b1 && out_vld === 1'b0, "R11 reset state", {30'd0, in_rdy, out_vld}, 32'd2);
    rst = 1'b0;
    @(negedge clk);

    // R1 R4 even block
    for (int i = 1; i <= 6; i++) send_byte(8'(i));
    send_byte(8'hFF);
    drain();

    // R6 odd block
    send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3);
    send_byte(8'hFF);
    drain();

    // R6 single byte
    send_byte(8'h42);
    send_byte(8'hFF);
    drain();

    // R10 lone terminator
    send_byte(8'hFF);
    check(in_rdy === 1'b1, "R10 lone terminator keeps ready", {31'd0, in_rdy}, 32'd1);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 no words", exp_q.size(), 0);

    // R8 strobes while busy
    for (int i = 0; i < 10; i++) send_byte(8'h10 + 8'(i));
    send_byte(8'hFF);
    for (int k = 0; k < 3; k++) begin
      check(in_rdy === 1'b0, "R8 busy deasserts ready", {31'd0, in_rdy}, 32'd0);
      in_byte = 8'h5A;
      in_vld  = 1'b1;
      @(negedge clk);
    end
    in_vld = 1'b0;
    drain();

    // R7 capacity without terminator, then lone terminator
    for (int i = 0; i < 64; i++) send_byte(8'((i * 7 + 3) & 8'h7F));
    check(in_rdy === 1'b0, "R7 full starts sending", {31'd0, in_rdy}, 32'd0);
    drain();
    send_byte(8'hFF);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 after full", exp_q.size(), 0);

    // R9 65 bytes: overflow byte opens new block at address 0
    for (int i = 0; i < 65; i++) send_byte(8'((i * 5 + 1) & 8'h7F));
    send_byte(8'hFF);
    drain();

    // R11 reset mid-block
    send_byte(8'h21); send_byte(8'h22); send_byte(8'h23);
    pend.delete();
    rst = 1'b1;
    @(negedge clk);
    check(in_rdy === 1'b1 && out_vld === 1'b0, "R11 reset mid-block", {30'd0, in_rdy, out_vld}, 32'd2);
    rst = 1'b0;
    @(negedge clk);
    send_byte(8'h31); send_byte(8'h32);
    send_byte(8'hFF);
    drain();

    check(exp_q.size() == 0, "R5 all words seen", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule